// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Look-Ahead Output

This block moves data words from one clock domain to another through a shared storage array. A producer writes on its own clock with a write strobe and a data word, and sees a full flag. A consumer reads on an unrelated clock with a read strobe and gets registered data, an empty flag, an almost-empty flag and a running count of the words taken out of storage. Each side's pointer goes to the other side in Gray code through a two-stage synchronizer. This makes the flag latency fixed and known.

A build-time parameter picks one of two read behaviours. In standard mode a word reaches the data output only in the cycle after the consumer asks for it. In look-ahead mode the block fetches the oldest word into the output register on its own, without a read strobe. The empty flag then means "no valid word on the output", and the read strobe acknowledges the word already shown. The fetch takes one extra read clock, so look-ahead mode reports "not empty" one cycle later than standard mode. Because the fetch removes a word from storage, it also advances the read count.

Top module: `dm_async_fifo`

## Requirements
- R1: After reset, empty=1, almost_empty=1, rd_count=0 and full=0.
- R2: Words come out in the order they were accepted. The first accepted word after reset goes to storage address 0, and no word is lost, duplicated or invented.
- R3: In standard mode (LOOKAHEAD=0), empty falls 3 read-clock edges after the write edge that put a word into an empty FIFO. It falls 4 edges after if the two edges come close together.
- R4: In look-ahead mode (LOOKAHEAD=1), empty falls 4 read-clock edges after that write, or 5 if the edges come close together. In the same cycle the first word is on rd_data with rd_en never asserted. A read with empty=0 takes away the word shown.
- R5: In standard mode, rd_data does not change while no read is accepted. A read accepted at a read edge presents its word on rd_data after that edge.
- R6: rd_count is the modulo-2^(AW+1) number of words taken out of storage. It steps by one for each accepted standard read. In look-ahead mode it steps by one for each internal fetch, including the first fetch that follows the write into an empty FIFO.
- R7: almost_empty is registered on the read clock. It is 1 when the fill level seen by the read side is at most AE_LEVEL (default 2); in look-ahead mode the level counts the word held in the output register. It is also 1 whenever empty is 1, so it never falls before empty.
- R8: full rises once 2^AW words are held in storage, as seen by the write side. A write while full is dropped and leaves the write pointer unchanged. In look-ahead mode the output register holds one more word, so a producer that never reads can place 2^AW+1 words.
- R9: A read while empty is dropped. In standard mode rd_count and rd_data stay unchanged. In look-ahead mode no word is consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| full | output | 1 | Storage full, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read strobe (acknowledge in look-ahead mode) |
| rd_data | output | DW | Registered output word |
| empty | output | 1 | No word available to the reader |
| almost_empty | output | 1 | Fill level at or below AE_LEVEL |
| rd_count | output | AW+1 | Words taken out of storage, wrapping |

## Verification
The bench measures how many read edges pass between a write into an empty FIFO and the fall of empty. A synchronizer stage too many or too few, or a look-ahead fetch that does not add its cycle, would fall outside the accepted window. In the same cycle it checks that the look-ahead output already shows the word and that the count reflects the fetch. A standard-mode design that leaks data early would change rd_data before any read. The bench also fills the FIFO with writes that go on past full, and counts how many are accepted in each mode: an off-by-one full compare, or a pointer that moves on a dropped write, would change the count or scramble the drained data. Random traffic on both sides catches lost or reordered words, and reads while empty are checked to leave the count and the data unchanged.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  // Binary to reflected Gray code on a 32-bit carrier; callers slice.
  function automatic logic [31:0] bin2gray32(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary; zero upper bits stay zero.
  function automatic logic [31:0] gray2bin32(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Registered read port; the register is the block's data output.
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side #(
  parameter int AW = 4,
  parameter int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] rq2_gray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr_gray,
  output logic          full
);

  import dmf_pkg::*;

  localparam logic [PW-1:0] FULL_GAP = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_n;
  logic [PW-1:0] rbin_seen;
  logic          full_n;

  always_comb begin
    we        = wr_en && !full;
    wbin_n    = wbin + PW'(we);
    rbin_seen = PW'(gray2bin32(32'(rq2_gray)));
    full_n    = ((wbin_n - rbin_seen) == FULL_GAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wptr_gray <= '0;
      full      <= 1'b0;
    end else begin
      wbin      <= wbin_n;
      wptr_gray <= PW'(bin2gray32(32'(wbin_n)));
      full      <= full_n;
    end
  end

  assign waddr = wbin[AW-1:0];

endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side #(
  parameter int AW        = 4,
  parameter int PW        = AW + 1,
  parameter bit LOOKAHEAD = 1'b1,
  parameter int AE_LEVEL  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] wq2_gray,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_gray,
  output logic [PW-1:0] count,
  output logic          empty,
  output logic          almost_empty
);

  import dmf_pkg::*;

  localparam int LW = PW + 1;

  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_n;
  logic [PW-1:0] wbin_seen;
  logic          store_empty;
  logic          store_empty_n;
  logic          out_valid;
  logic          out_valid_n;
  logic [LW-1:0] level_n;
  logic          ae_n;

  generate
    if (LOOKAHEAD) begin : g_look
      // Fetch whenever storage has a word and the output slot is free or being taken.
      always_comb begin
        re          = !store_empty && (!out_valid || rd_en);
        out_valid_n = re || (out_valid && !rd_en);
      end
      assign empty = !out_valid;
    end else begin : g_std
      always_comb begin
        re          = rd_en && !store_empty;
        out_valid_n = 1'b0;
      end
      assign empty = store_empty;
    end
  endgenerate

  always_comb begin
    wbin_seen     = PW'(gray2bin32(32'(wq2_gray)));
    rbin_n        = rbin + PW'(re);
    store_empty_n = (rbin_n == wbin_seen);
    level_n       = LW'(wbin_seen - rbin_n) + LW'(out_valid_n);
    ae_n          = (level_n <= LW'(AE_LEVEL)) || (LOOKAHEAD && !out_valid_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rptr_gray    <= '0;
      store_empty  <= 1'b1;
      out_valid    <= 1'b0;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_n;
      rptr_gray    <= PW'(bin2gray32(32'(rbin_n)));
      store_empty  <= store_empty_n;
      out_valid    <= out_valid_n;
      almost_empty <= ae_n;
    end
  end

  assign raddr = rbin[AW-1:0];
  assign count = rbin;

endmodule

// File: rtl/dm_async_fifo.sv
module dm_async_fifo #(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter bit LOOKAHEAD = 1'b1,
  parameter int AE_LEVEL  = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty,
  output logic [AW:0]   rd_count
);

  localparam int PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;
  logic [PW-1:0] w_gray_q;
  logic [PW-1:0] r_gray_q;
  logic [PW-1:0] w_gray_rd;
  logic [PW-1:0] r_gray_wr;

  dmf_wr_side #(.AW(AW), .PW(PW)) u_wr (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .wr_en    (wr_en),
    .rq2_gray (r_gray_wr),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wptr_gray(w_gray_q),
    .full     (full)
  );

  dmf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk),
    .rst(rd_rst),
    .d  (w_gray_q),
    .q  (w_gray_rd)
  );

  dmf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk),
    .rst(wr_rst),
    .d  (r_gray_q),
    .q  (r_gray_wr)
  );

  dmf_rd_side #(.AW(AW), .PW(PW), .LOOKAHEAD(LOOKAHEAD), .AE_LEVEL(AE_LEVEL)) u_rd (
    .clk         (rd_clk),
    .rst         (rd_rst),
    .rd_en       (rd_en),
    .wq2_gray    (w_gray_rd),
    .re          (mem_re),
    .raddr       (mem_raddr),
    .rptr_gray   (r_gray_q),
    .count       (rd_count),
    .empty       (empty),
    .almost_empty(almost_empty)
  );

  dmf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk (wr_clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(wr_data),
    .rclk (rd_clk),
    .rrst (rd_rst),
    .re   (mem_re),
    .raddr(mem_raddr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int DW        = 8,
  parameter int PW        = 5,
  parameter bit LOOKAHEAD = 1'b1
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_en,
  input logic          full,
  input logic [PW-1:0] wptr_gray,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_en,
  input logic          empty,
  input logic          almost_empty,
  input logic [PW-1:0] rd_count,
  input logic [DW-1:0] rd_data
);

  // R8
  full_hold_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (full && wr_en) |=> $stable(wptr_gray));

  // R2
  gray_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  // R9
  empty_read_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!LOOKAHEAD && empty && rd_en) |=> ($stable(rd_count) && $stable(rd_data)));

  // R6
  count_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + PW'(1)));

  // R7
  ae_covers_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |-> almost_empty);

  // R5
  std_read_adv_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!LOOKAHEAD && !empty && rd_en) |=> (rd_count == $past(rd_count) + PW'(1)));

endmodule

bind dm_async_fifo dmf_chk #(.DW(DW), .PW(AW + 1), .LOOKAHEAD(LOOKAHEAD)) u_dmf_chk (
  .wr_clk      (wr_clk),
  .wr_rst      (wr_rst),
  .wr_en       (wr_en),
  .full        (full),
  .wptr_gray   (w_gray_q),
  .rd_clk      (rd_clk),
  .rd_rst      (rd_rst),
  .rd_en       (rd_en),
  .empty       (empty),
  .almost_empty(almost_empty),
  .rd_count    (rd_count),
  .rd_data     (rd_data)
);

// File: tb/test_dm_async_fifo.sv
`timescale 1ns/1ps
module test_dm_async_fifo;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam int AE = 2;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic sel = 1'b0;
  logic [DW-1:0] din = '0;

  logic full_s, empty_s, ae_s, full_f, empty_f, ae_f;
  logic [DW-1:0] dout_s, dout_f;
  logic [AW:0] cnt_s, cnt_f;
  logic o_full, o_empty, o_ae;
  logic [DW-1:0] o_dout;
  logic [AW:0] o_cnt;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] q[$];
  bit wr_done;

  initial forever #2.5 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2.5 rd_clk = ~rd_clk;
  end

  dm_async_fifo #(.DW(DW), .AW(AW), .LOOKAHEAD(1'b1), .AE_LEVEL(AE)) i_dm_async_fifo (
    .wr_clk(wr_clk), .wr_rst(rst), .wr_en(wr_en & sel), .wr_data(din), .full(full_f),
    .rd_clk(rd_clk), .rd_rst(rst), .rd_en(rd_en & sel), .rd_data(dout_f),
    .empty(empty_f), .almost_empty(ae_f), .rd_count(cnt_f)
  );

  dm_async_fifo #(.DW(DW), .AW(AW), .LOOKAHEAD(1'b0), .AE_LEVEL(AE)) i_dm_async_fifo_std (
    .wr_clk(wr_clk), .wr_rst(rst), .wr_en(wr_en & ~sel), .wr_data(din), .full(full_s),
    .rd_clk(rd_clk), .rd_rst(rst), .rd_en(rd_en & ~sel), .rd_data(dout_s),
    .empty(empty_s), .almost_empty(ae_s), .rd_count(cnt_s)
  );

  always_comb begin
    o_full  = sel ? full_f  : full_s;
    o_empty = sel ? empty_f : empty_s;
    o_ae    = sel ? ae_f    : ae_s;
    o_dout  = sel ? dout_f  : dout_s;
    o_cnt   = sel ? cnt_f   : cnt_s;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d: actual=%0d expected=%0d", req, sel, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s mode=%0d: actual=%0d expected=%0d..%0d", req, sel, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    q.delete();
    repeat (4) @(negedge wr_clk);
    rst = 1'b0;
    repeat (3) @(negedge rd_clk);
    chk("R1 empty after reset", o_empty, 1);
    chk("R1 almost_empty after reset", o_ae, 1);
    chk("R1 rd_count after reset", o_cnt, 0);
    chk("R1 full after reset", o_full, 0);
  endtask

  task automatic write_one(input logic [DW-1:0] v);
    @(negedge wr_clk);
    din = v; wr_en = 1'b1;
    if (!o_full) q.push_back(v);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic read_one();
    logic [DW-1:0] e;
    int guard = 0;
    @(negedge rd_clk);
    while (o_empty && guard < 50) begin
      @(negedge rd_clk);
      guard++;
    end
    e = q.pop_front();
    if (sel) chk("R4 head word shown before acknowledge", o_dout, e);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (!sel) chk("R2 word order on standard read", o_dout, e);
  endtask

  task automatic test_latency();
    int lat = 0;
    int d_at = 0;
    int c_at = 0;
    int ae_at = 0;
    do_reset();
    @(negedge wr_clk);
    din = 8'hA5; wr_en = 1'b1;
    @(posedge wr_clk);
    for (int k = 1; k <= 8 && lat == 0; k++) begin
      @(negedge rd_clk);
      if (k == 1) wr_en = 1'b0;
      if (!o_empty) begin
        lat = k; d_at = o_dout; c_at = o_cnt; ae_at = o_ae;
      end
    end
    if (!sel) begin
      chk_rng("R3 standard empty latency", lat, 3, 4);
      chk("R5 output unchanged before read", d_at, 0);
      chk("R6 no count before standard read", c_at, 0);
    end else begin
      chk_rng("R4 look-ahead empty latency", lat, 4, 5);
      chk("R4 first word shown without read", d_at, 'hA5);
      chk("R6 fetch advances count", c_at, 1);
    end
    chk("R7 almost_empty held with one word", ae_at, 1);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk("R2 first word from address 0", o_dout, 'hA5);
    chk("R6 count after one word", o_cnt, 1);
    chk("R4 R5 empty after single word taken", o_empty, 1);
    rd_en = 1'b1;
    repeat (2) @(negedge rd_clk);
    rd_en = 1'b0;
    @(negedge rd_clk);
    chk("R9 count unchanged by read while empty", o_cnt, 1);
    chk("R9 data unchanged by read while empty", o_dout, 'hA5);
    chk("R9 still empty", o_empty, 1);
  endtask

  task automatic test_ae();
    do_reset();
    for (int i = 0; i < 4; i++) write_one(8'(8'h10 + i));
    repeat (10) @(negedge rd_clk);
    chk("R7 almost_empty low above level", o_ae, 0);
    while (q.size() > 0) begin
      read_one();
      chk("R7 almost_empty follows level", o_ae, (q.size() <= AE) ? 1 : 0);
    end
  endtask

  task automatic test_full();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge wr_clk);
      din = 8'(8'h30 + i); wr_en = 1'b1;
      if (!o_full) q.push_back(din);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    repeat (12) @(negedge rd_clk);
    chk("R8 full after overfill", o_full, 1);
    chk("R8 accepted word count", q.size(), DEPTH + (sel ? 1 : 0));
    chk("R7 almost_empty low when full", o_ae, 0);
    while (q.size() > 0) read_one();
    repeat (6) @(negedge wr_clk);
    chk("R8 full clears after drain", o_full, 0);
    chk("R9 empty after drain", o_empty, 1);
    chk("R7 almost_empty after drain", o_ae, 1);
  endtask

  task automatic test_random();
    do_reset();
    wr_done = 1'b0;
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge wr_clk);
          if (($urandom % 2) == 0) begin
            din = 8'($urandom);
            wr_en = 1'b1;
            if (!o_full) q.push_back(din);
          end else begin
            wr_en = 1'b0;
          end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        wr_done = 1'b1;
      end
      begin
        int guard = 0;
        bit pend = 1'b0;
        logic [DW-1:0] pexp = '0;
        while ((!wr_done || q.size() > 0 || pend) && guard < 20000) begin
          @(negedge rd_clk);
          guard++;
          if (pend) begin
            chk("R2 random standard order", o_dout, pexp);
            pend = 1'b0;
          end
          if (sel && !o_empty) begin
            if (q.size() == 0) chk("R2 no invented word", 1, 0);
            else chk("R2 random look-ahead head", o_dout, q[0]);
          end
          if (!o_empty && q.size() > 0 && ($urandom % 2) == 1) begin
            rd_en = 1'b1;
            if (sel) void'(q.pop_front());
            else begin
              pexp = q.pop_front();
              pend = 1'b1;
            end
          end else begin
            rd_en = 1'b0;
          end
        end
        rd_en = 1'b0;
      end
    join
    chk("R2 every word drained", q.size(), 0);
  endtask

  initial begin
    #900000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int m = 0; m < 2; m++) begin
      sel = m[0];
      test_latency();
      test_ae();
      test_full();
      test_random();
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule